// File: doc/BRIEF.md
# Calendar Real-Time Clock with Register Port

This block keeps wall-clock time as packed binary fields: seconds, minutes, hours, day of month, month, year within the century, and century. A one-cycle pulse on the tick input advances the time by one second while counting is enabled. The calendar handles month lengths and leap years, including the century rules. Software reaches it through a 32-bit word-aligned register port. A request lasts one cycle, and read data appears on the cycle after the request.

Two time words hold the packed fields. Software can write them only while the unlock control bit is set. A write to either time word, or any write to the control word, reloads the running calendar from the two stored time words. The value just written takes part in that reload. While the enable bit is set, a read of a time word returns the live time and also stores that value in the word. While the bit is clear, a read returns the stored word. The alarm word and the alarm status word are placeholders: they read as zero and ignore writes.

Top module: `rtc_calendar_top`

## Requirements
- R1: The time word at byte offset 0x00 carries day of month in bits 28:24, hour in 20:16, minute in 13:8 and second in 5:0. A value written there while unlocked reads back unchanged once counting is enabled, provided no tick has occurred.
- R2: The time word at byte offset 0x04 carries century in bits 20:16, year within the century in 14:8 and month in 3:0.
- R3: Reset, which is synchronous and active high, clears both time words, the control word, the running time and the read data.
- R4: Control bit 1 unlocks the time words. Writes to offsets 0x00 and 0x04 while it is clear change nothing. Writes to the control word at 0x10 are always accepted.
- R5: A write to a time word or to the control word reloads the running time from both stored time words, using the new value for the word being written.
- R6: While control bit 0 is set, each tick pulse advances the time by one second. While it is clear, the running time holds.
- R7: With bit 0 set, a time-word read returns the running time and copies it into that stored word. With bit 0 clear, a time-word read returns the stored word.
- R8: Seconds and minutes wrap from 59 to 0 with a carry, and hours wrap from 23 to 0 with a carry into the day.
- R9: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, after day 28 in February of a common year, and after day 31 in the other months.
- R10: For the full year century*100+year, February has 29 days when that year is divisible by 4 and not by 100, or is divisible by 400.
- R11: Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0 and increments the century.
- R12: The alarm (0x08) and alarm status (0x14) words and the unmapped offsets read zero, and writes to them have no effect. Unused bits of every word read zero, and a control read returns only bits 1:0.
- R13: Read data appears on the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| bus_valid_i | input | 1 | Register request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |

## Verification
The bench builds the block with the default ADDR_W of 5. With that width a byte address covers every mapped word, and it also reaches the unmapped offsets 0x0C, 0x18 and 0x1C, so the decode of unmapped offsets can be tested. The calendar field widths are fixed in the package. These widths let the bench load any century from 0 to 31. That range covers the year-2000 and year-2100 leap cases and the wrap from 2099 to 2100 through the normal register writes.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YR_W   = 7;
  localparam int CENT_W = 5;

  // word indices (byte offset / 4)
  localparam int IDX_LO   = 0;
  localparam int IDX_HI   = 1;
  localparam int IDX_ALM  = 2;
  localparam int IDX_CTRL = 4;
  localparam int IDX_STAT = 5;

  localparam logic [31:0] LO_MASK = 32'h1F1F_3F3F;
  localparam logic [31:0] HI_MASK = 32'h001F_7F0F;

  typedef struct packed {
    logic [CENT_W-1:0] cent;
    logic [YR_W-1:0]   yr;
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  mday;
    logic [HOUR_W-1:0] hours;
    logic [MIN_W-1:0]  mins;
    logic [SEC_W-1:0]  secs;
  } cal_t;

  function automatic logic [31:0] pack_lo(cal_t t);
    return {3'b0, t.mday, 3'b0, t.hours, 2'b0, t.mins, 2'b0, t.secs};
  endfunction

  function automatic logic [31:0] pack_hi(cal_t t);
    return {11'b0, t.cent, 1'b0, t.yr, 4'b0, t.mon};
  endfunction

  function automatic cal_t unpack_time(logic [31:0] lo, logic [31:0] hi);
    cal_t t;
    t.mday  = lo[28:24];
    t.hours = lo[20:16];
    t.mins  = lo[13:8];
    t.secs  = lo[5:0];
    t.cent  = hi[20:16];
    t.yr    = hi[14:8];
    t.mon   = hi[3:0];
    return t;
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic [MON_W-1:0]  mon_i,
  input  logic [YR_W-1:0]   yr_i,
  input  logic [CENT_W-1:0] cent_i,
  output logic [DAY_W-1:0]  last_day_o
);
  logic leap;

  // R10: 100 is a multiple of 4, so full-year mod 4 equals yr mod 4;
  // full year is a multiple of 100 only when yr is 0, and then of 400
  // only when the century is a multiple of 4.
  always_comb begin
    leap = ((yr_i[1:0] == 2'd0) && (yr_i != '0)) ||
           ((yr_i == '0) && (cent_i[1:0] == 2'd0));
    case (mon_i)
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): last_day_o = DAY_W'(30);
      MON_W'(2): last_day_o = leap ? DAY_W'(29) : DAY_W'(28);
      default:   last_day_o = DAY_W'(31);
    endcase
  end
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  cal_t load_val_i,
  input  logic step_i,
  output cal_t time_o
);
  cal_t cur_q, nxt;
  logic [DAY_W-1:0] last_day;
  logic w_sec, w_min, w_hour, w_day, w_mon, w_yr;

  rtc_month_len mlen_i (
    .mon_i      (cur_q.mon),
    .yr_i       (cur_q.yr),
    .cent_i     (cur_q.cent),
    .last_day_o (last_day)
  );

  always_comb begin
    w_sec  = cur_q.secs  >= SEC_W'(59);
    w_min  = cur_q.mins  >= MIN_W'(59);
    w_hour = cur_q.hours >= HOUR_W'(23);
    w_day  = cur_q.mday  >= last_day;
    w_mon  = cur_q.mon   >= MON_W'(12);
    w_yr   = cur_q.yr    >= YR_W'(99);
    nxt = cur_q;
    nxt.secs = w_sec ? '0 : cur_q.secs + 1'b1;
    if (w_sec) begin
      nxt.mins = w_min ? '0 : cur_q.mins + 1'b1;
      if (w_min) begin
        nxt.hours = w_hour ? '0 : cur_q.hours + 1'b1;
        if (w_hour) begin
          nxt.mday = w_day ? DAY_W'(1) : cur_q.mday + 1'b1;
          if (w_day) begin
            nxt.mon = w_mon ? MON_W'(1) : cur_q.mon + 1'b1;
            if (w_mon) begin
              nxt.yr = w_yr ? '0 : cur_q.yr + 1'b1;
              if (w_yr) nxt.cent = cur_q.cent + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cur_q <= '0;
    else if (load_i) cur_q <= load_val_i;
    else if (step_i) cur_q <= nxt;
  end

  assign time_o = cur_q;
endmodule

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  cal_t              live_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        ctrl_o,
  output logic              load_o,
  output cal_t              load_val_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic        wr, rd, wr_ctrl;
  logic [1:0]  ctrl_q;
  logic [1:0]  hit_time, wr_time;
  logic [31:0] store_q [2];
  logic [31:0] live_w  [2];
  logic [31:0] img     [2];

  assign word    = bus_addr_i[ADDR_W-1:2];
  assign wr      = bus_valid_i &&  bus_write_i;
  assign rd      = bus_valid_i && !bus_write_i;
  assign wr_ctrl = wr && (word == WORD_W'(IDX_CTRL));
  assign live_w[0] = pack_lo(live_i);
  assign live_w[1] = pack_hi(live_i);

  for (genvar g = 0; g < 2; g++) begin : g_word
    localparam logic [31:0] MASK = (g == 0) ? LO_MASK : HI_MASK;
    localparam int          IDX  = (g == 0) ? IDX_LO  : IDX_HI;
    assign hit_time[g] = (word == WORD_W'(IDX));
    assign wr_time[g]  = wr && hit_time[g] && ctrl_q[1];
    assign img[g]      = wr_time[g] ? (bus_wdata_i & MASK) : store_q[g];
    always_ff @(posedge clk) begin
      if (rst)                                store_q[g] <= '0;
      else if (wr_time[g])                    store_q[g] <= bus_wdata_i & MASK;
      else if (rd && hit_time[g] && ctrl_q[0]) store_q[g] <= live_w[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata_i[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (rd) begin
      if (hit_time[0])      rdata_o <= ctrl_q[0] ? live_w[0] : store_q[0];
      else if (hit_time[1]) rdata_o <= ctrl_q[0] ? live_w[1] : store_q[1];
      else if (word == WORD_W'(IDX_CTRL)) rdata_o <= {30'b0, ctrl_q};
      else rdata_o <= '0;
    end
  end

  assign load_o     = (|wr_time) || wr_ctrl;
  assign load_val_o = unpack_time(img[0], img[1]);
  assign ctrl_o     = ctrl_q;
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o
);
  cal_t       live_w, load_val_w;
  logic       load_w;
  logic [1:0] ctrl_w;

  rtc_cal_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .live_i      (live_w),
    .rdata_o     (bus_rdata_o),
    .ctrl_o      (ctrl_w),
    .load_o      (load_w),
    .load_val_o  (load_val_w)
  );

  rtc_cal_counter cnt_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .step_i     (tick_i && ctrl_w[0]),
    .time_o     (live_w)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic [1:0]        ctrl_i,
  input cal_t              live_i
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  logic any_wr, step, rd_void, rd_ctrl, wr_locked;

  assign word      = bus_addr_i[ADDR_W-1:2];
  assign any_wr    = bus_valid_i && bus_write_i;
  assign step      = tick_i && ctrl_i[0];
  assign rd_void   = bus_valid_i && !bus_write_i &&
                     (word == WORD_W'(IDX_ALM) || word == WORD_W'(IDX_STAT));
  assign rd_ctrl   = bus_valid_i && !bus_write_i && (word == WORD_W'(IDX_CTRL));
  assign wr_locked = any_wr && !ctrl_i[1] &&
                     (word == WORD_W'(IDX_LO) || word == WORD_W'(IDX_HI));

  assert_reset_clear_R3: assert property (@(posedge clk)
    rst |=> (bus_rdata_o == '0) && (live_i == '0));

  assert_alarm_zero_R12: assert property (@(posedge clk) disable iff (rst)
    rd_void |=> bus_rdata_o == '0);

  assert_ctrl_bits_R12: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl |=> bus_rdata_o[31:2] == '0);

  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_i[0] && !any_wr) |=> $stable(live_i));

  assert_locked_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_locked && !step) |=> $stable(live_i));

  assert_sec_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !any_wr && live_i.secs == SEC_W'(59)) |=> live_i.secs == '0);

  assert_sec_range_R8: assert property (@(posedge clk) disable iff (rst)
    (!any_wr && live_i.secs < SEC_W'(60)) |=> live_i.secs < SEC_W'(60));

  assert_year_end_R11: assert property (@(posedge clk) disable iff (rst)
    (step && !any_wr && live_i.mon == MON_W'(12) && live_i.mday == DAY_W'(31) &&
     live_i.hours == HOUR_W'(23) && live_i.mins == MIN_W'(59) &&
     live_i.secs == SEC_W'(59))
    |=> (live_i.mon == MON_W'(1)) && (live_i.mday == DAY_W'(1)));
endmodule

bind rtc_calendar_top rtc_calendar_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .tick_i      (tick_i),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .ctrl_i      (ctrl_w),
  .live_i      (live_w)
);

// File: tb/rtc_calendar_top_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_top_tb_top;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_LO = 5'h00, A_HI = 5'h04, A_ALM = 5'h08,
                                A_GAP = 5'h0C, A_CTRL = 5'h10, A_STAT = 5'h14,
                                A_TOP = 5'h18;
  localparam int NV = 13;
  // {tag, ticks, in_lo, in_hi, exp_lo, exp_hi}
  localparam logic [143:0] VEC [NV] = '{
    {8'd6,  8'd1, 32'h050A141E, 32'h00141703, 32'h050A141F, 32'h00141703}, // R6 one tick
    {8'd8,  8'd1, 32'h050A143B, 32'h00141703, 32'h050A1500, 32'h00141703}, // R8 minute carry
    {8'd8,  8'd1, 32'h05173B3B, 32'h00141703, 32'h06000000, 32'h00141703}, // R8 day carry
    {8'd9,  8'd1, 32'h1E173B3B, 32'h00141704, 32'h01000000, 32'h00141705}, // R9 April 30
    {8'd9,  8'd1, 32'h1F173B3B, 32'h00141701, 32'h01000000, 32'h00141702}, // R9 Jan 31
    {8'd9,  8'd1, 32'h1C173B3B, 32'h00141702, 32'h01000000, 32'h00141703}, // R9 Feb 28 2023
    {8'd10, 8'd1, 32'h1C173B3B, 32'h00141802, 32'h1D000000, 32'h00141802}, // R10 2024 leap
    {8'd10, 8'd1, 32'h1D173B3B, 32'h00141802, 32'h01000000, 32'h00141803}, // R10 Feb 29 end
    {8'd10, 8'd1, 32'h1C173B3B, 32'h00150002, 32'h01000000, 32'h00150003}, // R10 2100 common
    {8'd10, 8'd1, 32'h1C173B3B, 32'h00140002, 32'h1D000000, 32'h00140002}, // R10 2000 leap
    {8'd11, 8'd1, 32'h1F173B3B, 32'h0014630C, 32'h01000000, 32'h00150001}, // R11 century
    {8'd8,  8'd3, 32'h050A143A, 32'h00141703, 32'h050A1501, 32'h00141703}, // R8 three ticks
    {8'd1,  8'd0, 32'h0C0D2A07, 32'h001F630B, 32'h0C0D2A07, 32'h001F630B}  // R1 R2 layout
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_valid_i(bus_valid),
    .bus_write_i(bus_write), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    rd(A_LO, v);   chk("R3 lo", v, 32'h0);
    rd(A_HI, v);   chk("R3 hi", v, 32'h0);
    rd(A_CTRL, v); chk("R3 ctrl", v, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][143:136], i);
      wr(A_CTRL, 32'h2);
      wr(A_HI, VEC[i][95:64]);
      wr(A_LO, VEC[i][127:96]);
      wr(A_CTRL, 32'h3);
      pulse(int'(VEC[i][135:128]));
      rd(A_LO, v); chk(tag, v, VEC[i][63:32]);
      rd(A_HI, v); chk(tag, v, VEC[i][31:0]);
    end

    // R12 unused bits masked on write
    wr(A_CTRL, 32'h2);
    wr(A_LO, 32'hFFFF_FFFF);
    rd(A_LO, v); chk("R12 lo mask", v, 32'h1F1F3F3F);
    wr(A_HI, 32'hFFFF_FFFF);
    rd(A_HI, v); chk("R12 hi mask", v, 32'h001F7F0F);

    // R7 live read latches, R5 reload, R6 hold
    wr(A_HI, 32'h00141703);
    wr(A_LO, 32'h050A141E);
    wr(A_CTRL, 32'h3);
    pulse(2);
    rd(A_LO, v); chk("R7 live", v, 32'h050A1420);
    pulse(2);
    wr(A_CTRL, 32'h3);
    rd(A_LO, v); chk("R5 reload from stored", v, 32'h050A1420);
    wr(A_CTRL, 32'h2);
    pulse(3);
    rd(A_LO, v); chk("R6 hold disabled", v, 32'h050A1420);
    wr(A_CTRL, 32'h3);
    rd(A_LO, v); chk("R6 no drift", v, 32'h050A1420);

    // R4 locked writes ignored
    wr(A_CTRL, 32'h0);
    wr(A_LO, 32'h0);
    wr(A_HI, 32'h0);
    rd(A_LO, v); chk("R4 lo locked", v, 32'h050A1420);
    rd(A_HI, v); chk("R4 hi locked", v, 32'h00141703);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v); chk("R4 ctrl accepted", v, 32'h1);
    rd(A_LO, v); chk("R4 live intact", v, 32'h050A1420);

    // R12 alarm, status, unmapped
    wr(A_CTRL, 32'h0);
    wr(A_ALM, 32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_GAP, 32'hFFFF_FFFF);
    rd(A_ALM, v);  chk("R12 alarm", v, 32'h0);
    rd(A_STAT, v); chk("R12 status", v, 32'h0);
    rd(A_GAP, v);  chk("R12 gap", v, 32'h0);
    rd(A_TOP, v);  chk("R12 top", v, 32'h0);
    rd(A_LO, v);   chk("R12 lo untouched", v, 32'h050A1420);
    wr(A_CTRL, 32'hFFFF_FFFC);
    rd(A_CTRL, v); chk("R12 ctrl bits", v, 32'h0);

    // R13 read timing and hold
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = A_HI;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R13 next cycle", bus_rdata, 32'h00141703);
    repeat (3) @(negedge clk);
    chk("R13 hold", bus_rdata, 32'h00141703);

    // R3 reset mid-run
    wr(A_CTRL, 32'h3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(A_LO, v);   chk("R3 lo after rst", v, 32'h0);
    rd(A_CTRL, v); chk("R3 ctrl after rst", v, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule